// File: doc/BRIEF.md
# Windowed Frame Capture and 128-bit Beat Packer

This block takes a stream that carries four complex samples per clock and, when software asks for one, captures a fixed-length window of that stream onto a 128-bit AXI4-Stream master. The master typically feeds the write channel of a DMA engine. A single-cycle trigger arms one window. The window holds the number of frames programmed on a count input, and each frame is 512 samples, which is 128 beats. After the last beat of the window the block goes idle and waits for the next trigger.

The window starts wherever the incoming stream happens to be. It is not aligned to frame starts. A window of N frames therefore usually spans N+1 frame regions of the source, and its first and last pieces are partial frames.

Every accepted input cycle becomes one output beat. Lane 0, the earliest sample, is placed in the lowest 32 bits. TLAST marks each beat that carries an upstream end-of-frame marker, and it also marks the final beat of the window.

The output is a single register. While the downstream holds TREADY low, the beat in that register does not change. Any input beat that arrives during such a stall is discarded, is not counted, and is reported one cycle later on an overflow pulse.

Top module: `capture_packer128`

## Requirements
- R1: Output lane k (k = 0..3, lane 0 is the earliest sample of the cycle) occupies `m_tdata[32k+31:32k]`. Within a lane, bits [15:0] hold the real part from `in_re[16k+15:16k]` and bits [31:16] hold the imaginary part from `in_im[16k+15:16k]`.
- R2: A window delivers exactly `cap_frames` × 128 beats on the master. After the final beat, `m_tvalid` stays low until a new window is started.
- R3: A window starts at the clock edge where `cap_trigger` is sampled high while the block is idle. The first input beat accepted is the first one with `in_valid` high in a later cycle, whatever its position in the source frame.
- R4: `m_tlast` is high on every window beat whose input cycle had `in_eof` high, and on the final beat of the window.
- R5: While `m_tvalid` is low, `m_tdata` is all zeros and `m_tlast` is low.
- R6: A trigger is ignored while a window is active, including in the cycle of its final beat. A trigger is also ignored when `cap_frames` is 0 or greater than 1024.
- R7: The frame count is sampled at the trigger. Later changes on `cap_frames` do not change the running window. Counts up to 1024 are supported.
- R8: While `m_tvalid` is high and `m_tready` is low, `m_tdata` and `m_tlast` hold. An input beat arriving in such a cycle is dropped and not counted, and `overflow` is high for one cycle in the following cycle.
- R9: Cycles with `in_valid` low during a window produce no beat and are not counted.
- R10: After synchronous reset, `m_tvalid`, `m_tdata`, `m_tlast` and `overflow` are all zero and no window is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_trigger | input | 1 | Software request to start one window |
| cap_frames | input | 11 | Frames per window, sampled at the trigger |
| in_valid | input | 1 | Input cycle carries four samples |
| in_eof | input | 1 | Input cycle closes a source frame |
| in_re | input | 64 | Real parts, lane k at bits [16k+15:16k] |
| in_im | input | 64 | Imaginary parts, lane k at bits [16k+15:16k] |
| m_tready | input | 1 | Downstream ready |
| m_tvalid | output | 1 | Beat valid |
| m_tdata | output | 128 | Packed beat |
| m_tlast | output | 1 | Frame boundary or window end |
| overflow | output | 1 | One-cycle pulse after a dropped input beat |

## Verification
The bench starts windows both on a frame boundary and in mid-frame, and counts the TLAST beats in each case. A design that ignored the window end would show N markers instead of N+1 on an unaligned window. A design that marked the final beat twice would show extra markers on an aligned window.

It holds the trigger high throughout a window, changes the frame count mid-window, and tries the counts 0 and 1025. A design that re-armed, re-read the count, or accepted out-of-range counts would emit a wrong number of beats.

Stall and gap patterns check that held beats stay stable and that dropped or empty cycles are never counted. A design that got this wrong would end its windows early or late, or would show duplicated or skipped samples.

A 1024-frame window exposes an end-of-window counter that is too narrow or off by one.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int SAMPLE_W = 16;
    localparam int LANES    = 4;

    typedef struct packed {
        logic [SAMPLE_W-1:0] im;
        logic [SAMPLE_W-1:0] re;
    } cplx_t;

    typedef cplx_t [LANES-1:0] beat_t;

    localparam int BEAT_W = $bits(beat_t);
    localparam int BUS_W  = LANES * SAMPLE_W;

    function automatic int beats_per_frame(input int samples);
        return samples / LANES;
    endfunction
endpackage

// File: rtl/cap_lane_pack.sv
module cap_lane_pack
    import cap_pkg::*;
(
    input  logic [BUS_W-1:0] re_bus,
    input  logic [BUS_W-1:0] im_bus,
    output beat_t            beat
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign beat[k].re = re_bus[k*SAMPLE_W +: SAMPLE_W];
        assign beat[k].im = im_bus[k*SAMPLE_W +: SAMPLE_W];
    end
endmodule

// File: rtl/cap_window.sv
module cap_window #(
    parameter int FRAME_BEATS = 128,
    parameter int MAX_FRAMES  = 1024,
    localparam int NFR_W      = $clog2(MAX_FRAMES + 1),
    localparam int CNT_W      = $clog2(MAX_FRAMES * FRAME_BEATS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic [NFR_W-1:0] nframes,
    input  logic             beat_take,
    output logic             active,
    output logic             final_beat
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;
    logic             start_ok;

    assign start_ok   = start_req && !active && (nframes != '0)
                        && (nframes <= NFR_W'(MAX_FRAMES));
    assign final_beat = active && (cnt == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cnt      <= '0;
            last_idx <= '0;
        end else if (active) begin
            if (beat_take) begin
                if (final_beat) begin
                    active <= 1'b0;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end else if (start_ok) begin
            active   <= 1'b1;
            cnt      <= '0;
            last_idx <= CNT_W'(nframes) * CNT_W'(FRAME_BEATS) - 1'b1;
        end
    end

    // R2: counter never passes the window end
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt <= last_idx));

    // R2: the final accepted beat closes the window
    assert_stop_R2: assert property (@(posedge clk) disable iff (rst)
        (beat_take && final_beat) |=> !active);

    // R6 R7: a running window survives triggers and keeps its length
    assert_ignore_trig_R6: assert property (@(posedge clk) disable iff (rst)
        (active && !(beat_take && final_beat)) |=> (active && $stable(last_idx)));
endmodule

// File: rtl/cap_out_reg.sv
module cap_out_reg
    import cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  beat_t             load_beat,
    input  logic              load_last,
    input  logic              tready,
    output logic              tvalid,
    output logic [BEAT_W-1:0] tdata,
    output logic              tlast
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tvalid <= 1'b0;
            tdata  <= '0;
            tlast  <= 1'b0;
        end else if (load) begin
            tvalid <= 1'b1;
            tdata  <= load_beat;
            tlast  <= load_last;
        end else if (tready) begin
            tvalid <= 1'b0;
            tdata  <= '0;
            tlast  <= 1'b0;
        end
    end

    // R8: a stalled beat holds
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tlast)));

    // R5: idle output carries zeros
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !tvalid |-> ((tdata == '0) && !tlast));
endmodule

// File: rtl/capture_packer128.sv
module capture_packer128
    import cap_pkg::*;
#(
    parameter int FRAME_SAMPLES = 512,
    parameter int MAX_FRAMES    = 1024,
    localparam int FRAME_BEATS  = FRAME_SAMPLES / LANES,
    localparam int NFR_W        = $clog2(MAX_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_trigger,
    input  logic [NFR_W-1:0]  cap_frames,
    input  logic              in_valid,
    input  logic              in_eof,
    input  logic [BUS_W-1:0]  in_re,
    input  logic [BUS_W-1:0]  in_im,
    input  logic              m_tready,
    output logic              m_tvalid,
    output logic [BEAT_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic              overflow
);
    logic  active;
    logic  final_beat;
    logic  take;
    logic  drop;
    beat_t packed_beat;

    assign take = active && in_valid && (!m_tvalid || m_tready);
    assign drop = active && in_valid && m_tvalid && !m_tready;

    cap_window #(
        .FRAME_BEATS (FRAME_BEATS),
        .MAX_FRAMES  (MAX_FRAMES)
    ) i_window (
        .clk        (clk),
        .rst        (rst),
        .start_req  (cap_trigger),
        .nframes    (cap_frames),
        .beat_take  (take),
        .active     (active),
        .final_beat (final_beat)
    );

    cap_lane_pack i_pack (
        .re_bus (in_re),
        .im_bus (in_im),
        .beat   (packed_beat)
    );

    cap_out_reg i_out (
        .clk       (clk),
        .rst       (rst),
        .load      (take),
        .load_beat (packed_beat),
        .load_last (in_eof || final_beat),
        .tready    (m_tready),
        .tvalid    (m_tvalid),
        .tdata     (m_tdata),
        .tlast     (m_tlast)
    );

    always_ff @(posedge clk) begin
        if (rst) overflow <= 1'b0;
        else     overflow <= drop;
    end

    // R8: overflow only follows an input beat met by a stall
    assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (rst)
        overflow |-> $past(m_tvalid && !m_tready && in_valid));

    // R2: no beat appears while no window is running and none is pending
    assert_no_stray_R2: assert property (@(posedge clk) disable iff (rst)
        (!active && !m_tvalid) |=> !m_tvalid);
endmodule

// File: tb/test_capture_packer128.sv
module test_capture_packer128;
    logic         clk = 1'b0;
    logic         rst;
    logic         cap_trigger;
    logic [10:0]  cap_frames;
    logic         in_valid;
    logic         in_eof;
    logic [63:0]  in_re;
    logic [63:0]  in_im;
    logic         m_tready;
    logic         m_tvalid;
    logic [127:0] m_tdata;
    logic         m_tlast;
    logic         overflow;

    always #2.5 clk = ~clk;

    capture_packer128 i_capture_packer128 (
        .clk         (clk),
        .rst         (rst),
        .cap_trigger (cap_trigger),
        .cap_frames  (cap_frames),
        .in_valid    (in_valid),
        .in_eof      (in_eof),
        .in_re       (in_re),
        .in_im       (in_im),
        .m_tready    (m_tready),
        .m_tvalid    (m_tvalid),
        .m_tdata     (m_tdata),
        .m_tlast     (m_tlast),
        .overflow    (overflow)
    );

    int checks   = 0;
    int failures = 0;

    // reference model state
    bit           m_active;
    int           m_cnt;
    int           m_total;
    bit           e_valid;
    logic [127:0] e_data;
    bit           e_last;
    bit           e_ovf;
    int           gen_pos;
    int           gen_frame;
    int           nfr_in;
    int           beats_out;
    int           lasts_out;
    int           ovf_seen;

    function automatic logic [127:0] exp_beat(input int pos, input int frm);
        logic [127:0] r;
        logic [15:0]  f16;
        r   = '0;
        f16 = 16'(frm);
        for (int k = 0; k < 4; k++) begin
            r[32*k +: 16]      = 16'(pos*4 + k);
            r[32*k + 16 +: 16] = {f16[13:0], 2'(k)};
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        chk(m_tvalid === e_valid, "R2 tvalid", 128'(m_tvalid), 128'(e_valid));
        if (e_valid) begin
            chk(m_tdata === e_data, "R1 tdata", m_tdata, e_data);
            chk(m_tlast === e_last, "R4 tlast", 128'(m_tlast), 128'(e_last));
        end else begin
            chk(m_tdata === '0 && m_tlast === 1'b0, "R5 idle zero",
                m_tdata, 128'(0));
        end
        chk(overflow === e_ovf, "R8 overflow", 128'(overflow), 128'(e_ovf));
    endtask

    task automatic step(input bit trg, input bit rdy, input bit vld);
        bit acc;
        bit drop;
        bit fin;
        @(negedge clk);
        check_outputs();
        cap_trigger = trg;
        m_tready    = rdy;
        cap_frames  = 11'(nfr_in);
        in_valid    = vld;
        in_eof      = vld && (gen_pos == 127);
        in_re = '0;
        in_im = '0;
        if (vld) begin
            for (int k = 0; k < 4; k++) begin
                in_re[16*k +: 16] = exp_beat(gen_pos, gen_frame)[32*k +: 16];
                in_im[16*k +: 16] = exp_beat(gen_pos, gen_frame)[32*k + 16 +: 16];
            end
        end
        if (m_tvalid && rdy) begin
            beats_out++;
            if (m_tlast) lasts_out++;
        end
        acc  = m_active && vld && (!e_valid || rdy);
        drop = m_active && vld && e_valid && !rdy;
        fin  = (m_cnt == m_total - 1);
        if (acc) begin
            e_valid = 1'b1;
            e_data  = exp_beat(gen_pos, gen_frame);
            e_last  = (gen_pos == 127) || fin;
            if (fin) begin
                m_active = 1'b0;
                m_cnt    = 0;
            end else begin
                m_cnt++;
            end
        end else begin
            if (rdy) begin
                e_valid = 1'b0;
                e_data  = '0;
                e_last  = 1'b0;
            end
            if (!m_active && trg && nfr_in >= 1 && nfr_in <= 1024) begin
                m_active = 1'b1;
                m_cnt    = 0;
                m_total  = nfr_in * 128;
            end
        end
        e_ovf = drop;
        if (drop) ovf_seen++;
        if (vld) begin
            if (gen_pos == 127) begin
                gen_pos = 0;
                gen_frame++;
            end else begin
                gen_pos++;
            end
        end
    endtask

    task automatic clear_counts();
        beats_out = 0;
        lasts_out = 0;
        ovf_seen  = 0;
    endtask

    task automatic run_until_pos(input int pos);
        while (gen_pos != pos) step(1'b0, 1'b1, 1'b1);
    endtask

    task automatic drain();
        int guard = 0;
        while ((m_active || e_valid) && guard < 150000) begin
            step(1'b0, 1'b1, 1'b1);
            guard++;
        end
        repeat (20) step(1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cap_trigger = 1'b0; cap_frames = '0; in_valid = 1'b0; in_eof = 1'b0;
        in_re = '0; in_im = '0; m_tready = 1'b1;
        m_active = 0; m_cnt = 0; m_total = 0; e_valid = 0; e_data = '0;
        e_last = 0; e_ovf = 0; gen_pos = 0; gen_frame = 0; nfr_in = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(m_tvalid === 1'b0 && m_tdata === '0 && m_tlast === 1'b0 && overflow === 1'b0,
            "R10 reset state", {m_tvalid, m_tlast, overflow}, 128'(0));
        repeat (5) step(1'b0, 1'b1, 1'b1);
    endtask

    // R3 R4: window aligned to a frame start, final beat coincides with eof
    task automatic t_aligned();
        clear_counts();
        nfr_in = 2;
        run_until_pos(127);
        step(1'b1, 1'b1, 1'b1);
        drain();
        chk(beats_out == 256, "R2 aligned beats", 128'(beats_out), 128'(256));
        chk(lasts_out == 2, "R4 aligned tlast count", 128'(lasts_out), 128'(2));
    endtask

    // R3 R4: mid-frame start spans nframes+1 regions
    task automatic t_midframe();
        clear_counts();
        nfr_in = 3;
        run_until_pos(40);
        step(1'b1, 1'b1, 1'b1);
        drain();
        chk(beats_out == 384, "R3 midframe beats", 128'(beats_out), 128'(384));
        chk(lasts_out == 4, "R4 midframe tlast count", 128'(lasts_out), 128'(4));
    endtask

    // R6 R7: trigger held and count changed during the window
    task automatic t_retrigger();
        int i = 0;
        clear_counts();
        nfr_in = 2;
        run_until_pos(10);
        step(1'b1, 1'b1, 1'b1);
        while (m_active) begin
            if (i == 50) nfr_in = 5;
            step(1'b1, 1'b1, 1'b1);
            i++;
        end
        nfr_in = 2;
        repeat (40) step(1'b0, 1'b1, 1'b1);
        chk(beats_out == 256, "R6 retrigger ignored beats", 128'(beats_out), 128'(256));
        chk(lasts_out == 3, "R7 latched count tlast", 128'(lasts_out), 128'(3));
    endtask

    // R6: counts 0 and 1025 start nothing
    task automatic t_bad_count();
        clear_counts();
        nfr_in = 0;
        step(1'b1, 1'b1, 1'b1);
        repeat (20) step(1'b0, 1'b1, 1'b1);
        nfr_in = 1025;
        step(1'b1, 1'b1, 1'b1);
        repeat (20) step(1'b0, 1'b1, 1'b1);
        chk(beats_out == 0, "R6 bad count no beats", 128'(beats_out), 128'(0));
    endtask

    // R8: stalls hold the beat, drop input, pulse overflow
    task automatic t_stall();
        int i = 0;
        clear_counts();
        nfr_in = 2;
        run_until_pos(70);
        step(1'b1, 1'b1, 1'b1);
        while ((m_active || e_valid) && i < 5000) begin
            step(1'b0, (i % 3) != 2, 1'b1);
            i++;
        end
        repeat (10) step(1'b0, 1'b1, 1'b1);
        chk(beats_out == 256, "R8 stall beat total", 128'(beats_out), 128'(256));
        chk(ovf_seen > 0, "R8 overflow exercised", 128'(ovf_seen), 128'(1));
    endtask

    // R9: idle input cycles are not counted
    task automatic t_gaps();
        int i = 0;
        clear_counts();
        nfr_in = 1;
        run_until_pos(60);
        step(1'b1, 1'b1, 1'b1);
        while ((m_active || e_valid) && i < 5000) begin
            step(1'b0, 1'b1, (i % 4) != 1);
            i++;
        end
        repeat (10) step(1'b0, 1'b1, 1'b1);
        chk(beats_out == 128, "R9 gap beat total", 128'(beats_out), 128'(128));
        chk(lasts_out == 2, "R9 gap tlast count", 128'(lasts_out), 128'(2));
    endtask

    // R7: maximum window of 1024 frames
    task automatic t_long();
        clear_counts();
        nfr_in = 1024;
        run_until_pos(5);
        step(1'b1, 1'b1, 1'b1);
        drain();
        chk(beats_out == 131072, "R7 max window beats", 128'(beats_out), 128'(131072));
        chk(lasts_out == 1025, "R7 max window tlast", 128'(lasts_out), 128'(1025));
    endtask

    initial begin
        t_reset();
        t_aligned();
        t_midframe();
        t_retrigger();
        t_bad_count();
        t_stall();
        t_gaps();
        t_long();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired (R2) actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule